// File: doc/BRIEF.md
# Alternate Pulse Gate

This block watches a single pulse line and lets every second pulse through to its output. The pulses it lets through keep their full width. The pulses in between are held back completely. Pulse widths and the gaps between pulses may be any length. The block never counts a duration: it reacts only to changes in the level of the input.

Inside, a two-flop synchronizer brings the raw line into the clock domain. A four-state Moore machine then advances once on every change of the synchronized level. The output depends only on the current state. The state codes run round a Gray cycle, so every legal step flips a single state bit.

Typical use is halving the rate of a pulse stream that comes from another clock domain while keeping each kept pulse intact.

Top module: `alt_pulse_gate`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, and from then on until the next input pulse, `gate_out` is 0. When reset is released with `pulse_in` low, the first pulse that follows is forwarded.
- R2: Counting the pulses on `pulse_in` since reset, numbers 1, 3, 5 and so on are forwarded and numbers 2, 4, 6 and so on are suppressed. A suppressed pulse leaves `gate_out` at 0 for its whole duration.
- R3: A forwarded pulse that is high for N clock cycles produces exactly one output pulse, high for N cycles. The output is never high unless the synchronized input was high one cycle earlier.
- R4: With the default two synchronizer stages, `gate_out` rises exactly three rising clock edges after `pulse_in` rises, and falls exactly three edges after `pulse_in` falls, for every high and low duration of at least two cycles.
- R5: The state codes are: pass-wait 00, pass-active 01, block-wait 11, block-active 10. The state always moves forward through that cycle, one step per input level change. No step changes more than one state bit.
- R6: While the synchronized input level stays constant, the state and `gate_out` do not change, however long that level lasts.
- R7: If `pulse_in` is already high, and has been for at least two cycles, when reset is released, that pulse is suppressed. The next pulse after it is forwarded.
- R8: Asserting `rst` in the middle of a forwarded pulse drives `gate_out` to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Raw pulse line; may be asynchronous to clk |
| gate_out | output | 1 | Every second input pulse, full width |

## Verification
The hardest situation to reach from the ports is reset released while a pulse is already under way. Reaching it needs `pulse_in` held high through the last reset cycles, so that the synchronized level is high from the first cycle after reset. The bench builds this situation in two ways. In the first, reset is asserted in the middle of a forwarded pulse and released with the input still high. In the second, the pulse then ends and a fresh pulse follows. This checks that the partial pulse is blocked and that the fresh pulse is forwarded. The alternation is also kept going across a table of pulse shapes, then a long run of random widths, then very long holds. This drives the state through many full cycles, so that any illegal step is caught.

// File: rtl/alt_gate_pkg.sv
package alt_gate_pkg;

    // Gray cycle: each forward step flips one bit
    typedef enum logic [1:0] {
        GS_PASS_WAIT = 2'b00,
        GS_PASS_ACT  = 2'b01,
        GS_BLK_WAIT  = 2'b11,
        GS_BLK_ACT   = 2'b10
    } gate_state_e;

    localparam int SYNC_STAGES_DEF = 2;

    // next state in the cycle
    function automatic gate_state_e gs_succ(input gate_state_e s);
        gate_state_e n;
        case (s)
            GS_PASS_WAIT: n = GS_PASS_ACT;
            GS_PASS_ACT:  n = GS_BLK_WAIT;
            GS_BLK_WAIT:  n = GS_BLK_ACT;
            default:      n = GS_PASS_WAIT;
        endcase
        return n;
    endfunction

    // input level that keeps a state stable
    function automatic logic gs_hold_level(input gate_state_e s);
        logic h;
        case (s)
            GS_PASS_ACT, GS_BLK_ACT: h = 1'b1;
            default:                 h = 1'b0;
        endcase
        return h;
    endfunction

    // Moore output of a state
    function automatic logic gs_drives(input gate_state_e s);
        return (s == GS_PASS_ACT);
    endfunction

endpackage

// File: rtl/alt_level_sync.sv
module alt_level_sync #(
    parameter int STAGES = alt_gate_pkg::SYNC_STAGES_DEF
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // no reset: the chain must track the line during reset
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) chain_q <= d_i;
        end else begin : g_multi
            always_ff @(posedge clk_i) chain_q <= {chain_q[LAST-1:0], d_i};
        end
    endgenerate

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/alt_gate_fsm.sv
module alt_gate_fsm
    import alt_gate_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        lvl_i,
    output gate_state_e state_o
);
    gate_state_e state_q, state_d;
    logic        armed_q;

    always_comb begin
        state_d = state_q;
        if (lvl_i != gs_hold_level(state_q)) begin
            if (state_q == GS_PASS_WAIT && !armed_q)
                state_d = GS_BLK_ACT;   // pulse already running at release
            else
                state_d = gs_succ(state_q);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= GS_PASS_WAIT;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= 1'b1;
        end
    end

    assign state_o = state_q;

    // R5
    one_bit_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> ($countones(state_q ^ $past(state_q)) <= 1));

    // R5
    cyclic_order_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(armed_q) && (state_q != $past(state_q)))
            |-> (state_q == gs_succ($past(state_q))));

    // R6
    hold_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed_q && !$past(rst_i) && $stable(lvl_i)) |=> $stable(state_q));
endmodule

// File: rtl/alt_gate_decode.sv
module alt_gate_decode
    import alt_gate_pkg::*;
(
    input  gate_state_e state_i,
    output logic        pulse_o
);
    assign pulse_o = gs_drives(state_i);
endmodule

// File: rtl/alt_pulse_gate.sv
module alt_pulse_gate #(
    parameter int SYNC_STAGES = alt_gate_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic gate_out
);
    import alt_gate_pkg::*;

    logic        lvl;
    gate_state_e state;

    alt_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk),
        .d_i   (pulse_in),
        .q_o   (lvl)
    );

    alt_gate_fsm u_fsm (
        .clk_i   (clk),
        .rst_i   (rst),
        .lvl_i   (lvl),
        .state_o (state)
    );

    alt_gate_decode u_dec (
        .state_i (state),
        .pulse_o (gate_out)
    );

    // R3
    out_follows_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && gate_out) |-> $past(lvl));
endmodule

// File: tb/tb_alt_pulse_gate.sv
`timescale 1ns/1ps
module tb_alt_pulse_gate;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse_in = 1'b0;
    logic gate_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected-output delay line (three edges of latency)
    logic p0 = 0, p1 = 0, p2 = 0;
    int run = 0;
    int seen_w [0:127];
    int exp_w  [0:127];
    int n_seen = 0;
    int n_exp  = 0;
    bit par = 1;   // next pulse passes

    // {high cycles, low cycles, passes}
    localparam int NV = 12;
    localparam int VEC [NV][3] = '{
        '{2, 2, 1}, '{3, 2, 0}, '{2, 5, 1}, '{7, 3, 0},
        '{4, 4, 1}, '{2, 9, 0}, '{9, 2, 1}, '{5, 6, 0},
        '{3, 3, 1}, '{6, 2, 0}, '{2, 3, 1}, '{8, 4, 0}
    };

    alt_pulse_gate dut (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (pulse_in),
        .gate_out (gate_out)
    );

    always #2 clk = ~clk;

    task automatic check(input logic act, input logic expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: gate_out=%0b expected %0b at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic check_int(input int act, input int expv, input string tag);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // one clock: drive, then sample after the edge
    task automatic cyc(input logic v, input logic e, input logic r, input string tag);
        rst = r;
        pulse_in = v;
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            p0 = 0; p1 = 0; p2 = 0;
            run = 0;
            check(gate_out, 1'b0, tag);
        end else begin
            p2 = p1; p1 = p0; p0 = e;
            check(gate_out, p2, tag);
            if (gate_out === 1'b1) run++;
            else if (run > 0) begin
                seen_w[n_seen] = run;
                n_seen++;
                run = 0;
            end
        end
    endtask

    task automatic pulse(input int hi, input int lo, input bit pass, input string tag);
        if (pass) begin
            exp_w[n_exp] = hi;
            n_exp++;
        end
        for (int i = 0; i < hi; i++) cyc(1'b1, pass, 1'b0, tag);
        for (int i = 0; i < lo; i++) cyc(1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset with input low, output idle
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b1, "R1");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, "R1");

        // R2: table of shapes, alternation from the table
        for (int k = 0; k < NV; k++)
            pulse(VEC[k][0], VEC[k][1], VEC[k][2] != 0, "R2");
        par = 1;

        // R4: random widths, edge latency checked every cycle
        for (int k = 0; k < 20; k++) begin
            pulse(2 + int'($urandom % 9), 2 + int'($urandom % 9), par, "R4");
            par = !par;
        end

        // R6: very long levels
        pulse(40, 40, par, "R6");
        par = !par;
        pulse(40, 10, par, "R6");
        par = !par;

        // R8: make the next pulse a passed one, then reset inside it
        if (!par) begin
            pulse(3, 3, 1'b0, "R8");
            par = 1;
        end
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1, "R8");

        // R7: released while high, partial pulse suppressed
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, "R7");
        pulse(3, 3, 1'b1, "R7");
        pulse(4, 3, 1'b0, "R7");
        pulse(2, 6, 1'b1, "R7");

        // R3: widths and counts of output pulses
        check_int(n_seen, n_exp, "R3 count");
        for (int k = 0; k < n_exp && k < n_seen; k++)
            check_int(seen_w[k], exp_w[k], "R3 width");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule